// File: doc/BRIEF.md
# Early branch resolution fetch unit

This block holds the program counter of a five-stage in-order pipeline and controls the IF/ID register. Fetch is sequential by default: it assumes every branch is not taken and keeps stepping the PC by 4. The decode stage presents a branch by asserting a valid flag with two 32-bit register operands, a sign-extended word offset and the PC of the branch. The block compares the operands and forms the target in that same cycle. If the branch is taken, the block loads the target into the PC and discards the one instruction that was fetched behind the branch. A taken branch therefore costs a single bubble.

The discarded instruction becomes an all-zero NOP in the IF/ID register, and that entry's valid bit is cleared, so later stages cannot let it write a register or memory. An external hazard unit can stall the block, which freezes the PC and the IF/ID register. The instruction memory sits outside the block and returns its word combinationally for the current fetch address.

Top module: `branch_fetch_ctl`

## Requirements
- R1: A synchronous active-high `rst` sets `fetch_pc` to 0x00000000, `dec_valid` to 0 and `dec_instr` to 0x00000000 at the next rising edge.
- R2: When neither a stall nor a taken branch is present, `fetch_pc` rises by 4 at each edge. `dec_instr` takes the `imem_rdata` word of the old fetch address, and `dec_valid` becomes 1.
- R3: When `br_valid`=1, `br_ne`=0 and `opnd_a`==`opnd_b`, the branch is taken and the next `fetch_pc` is `dec_pc` + 4 + `imm_ext`×4, using 32-bit wrapping two's-complement arithmetic. A branch at 40 with offset 7 goes to 72, and a negative offset gives a backward target.
- R4: When `br_valid`=1, `br_ne`=1 and `opnd_a`!=`opnd_b`, the branch is taken with the same target rule as R3.
- R5: A branch whose condition fails (equal-type with different operands, or not-equal-type with equal operands) is not taken. `flush` stays 0 and fetch continues at `fetch_pc` + 4.
- R6: `flush` is 1 in the same cycle as a taken branch. At the next edge the IF/ID register is loaded with the NOP 0x00000000 and `dec_valid`=0.
- R7: While `stall`=1 and no branch is taken, `fetch_pc`, `dec_instr` and `dec_valid` keep their values.
- R8: A taken branch during `stall`=1 still redirects the PC and flushes the IF/ID register. The flush wins over the stall.
- R9: When `br_valid`=0, the operands, offset and decode PC have no effect: `flush` stays 0 and fetch behaves as in R2 or R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold request from the hazard unit |
| imem_rdata | input | 32 | Instruction word at `fetch_pc` |
| br_valid | input | 1 | Decode holds a conditional branch |
| br_ne | input | 1 | Condition select: 0 means branch if equal, 1 means branch if not equal |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| imm_ext | input | 32 | Sign-extended word offset |
| dec_pc | input | 32 | PC of the instruction in decode |
| fetch_pc | output | 32 | Fetch address |
| flush | output | 1 | Squash request for the IF/ID register |
| dec_instr | output | 32 | Instruction word passed to decode |
| dec_valid | output | 1 | Valid bit of the IF/ID register |

## Verification
The branch decision is tried with all four combinations of condition select and operand equality. This tells a correct comparator apart from one that has the sense inverted or that ignores the select. The target is checked with a forward offset (40 + 7 words goes to 72), a backward negative offset and a larger positive offset, which separates correct scaling and sign handling from an unscaled or zero-extended add. The bench also applies a stall on its own, a stall together with a taken branch, and equal operands with the branch flag low. These show that the hold, the flush-over-stall priority and the gating by the valid flag are each separate from plain sequential fetch.

// File: rtl/branch_fetch_ctl.sv
module branch_fetch_ctl #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] imem_rdata,
  input  logic            br_valid,
  input  logic            br_ne,
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic [XLEN-1:0] imm_ext,
  input  logic [XLEN-1:0] dec_pc,
  output logic [XLEN-1:0] fetch_pc,
  output logic            flush,
  output logic [XLEN-1:0] dec_instr,
  output logic            dec_valid
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam logic [XLEN-1:0] NOP  = '0;

  logic            same;
  logic [XLEN-1:0] target;

  assign same   = (opnd_a == opnd_b);
  assign flush  = br_valid & (same ^ br_ne);
  assign target = dec_pc + STEP + (imm_ext << 2);

  always_ff @(posedge clk) begin
    if (rst)         fetch_pc <= RESET_PC;
    else if (flush)  fetch_pc <= target;
    else if (!stall) fetch_pc <= fetch_pc + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      dec_instr <= NOP;
      dec_valid <= 1'b0;
    end else if (!stall) begin
      dec_instr <= imem_rdata;
      dec_valid <= 1'b1;
    end
  end

  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (fetch_pc == RESET_PC && !dec_valid && dec_instr == NOP));

  // R2, R5, R9: sequential fetch when nothing redirects or holds
  assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    (!stall && !flush) |=> (fetch_pc == $past(fetch_pc) + STEP && dec_valid
                            && dec_instr == $past(imem_rdata)));

  // R3, R4: taken branch lands on pc + 4 + offset words
  assert_taken_target_R3: assert property (@(posedge clk) disable iff (rst)
    (br_valid && (opnd_a == opnd_b) != br_ne)
      |=> fetch_pc == $past(dec_pc) + STEP + {$past(imm_ext[XLEN-3:0]), 2'b00});

  // R6, R8: squashed slot is a NOP that can never commit
  assert_flush_nop_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!dec_valid && dec_instr == NOP));

  // R7: stall freezes PC and IF/ID
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |=> ($stable(fetch_pc) && $stable(dec_instr) && $stable(dec_valid)));
endmodule

// File: tb/test_branch_fetch_ctl.sv
module test_branch_fetch_ctl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] imem_rdata;
  logic        br_valid = 1'b0;
  logic        br_ne = 1'b0;
  logic [31:0] opnd_a = '0, opnd_b = '0, imm_ext = '0, dec_pc = '0;
  logic [31:0] fetch_pc, dec_instr;
  logic        flush, dec_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] m_pc = '0, m_instr = '0;
  logic        m_valid = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign imem_rdata = mem_word(fetch_pc);

  branch_fetch_ctl i_branch_fetch_ctl (
    .clk(clk), .rst(rst), .stall(stall), .imem_rdata(imem_rdata),
    .br_valid(br_valid), .br_ne(br_ne), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .imm_ext(imm_ext), .dec_pc(dec_pc), .fetch_pc(fetch_pc), .flush(flush),
    .dec_instr(dec_instr), .dec_valid(dec_valid)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input string tag, input bit r, input bit s, input bit bv,
                      input bit ne, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] imm, input logic [31:0] dpc);
    bit taken;
    logic [31:0] fetched;
    @(negedge clk);
    rst = r; stall = s; br_valid = bv; br_ne = ne;
    opnd_a = a; opnd_b = b; imm_ext = imm; dec_pc = dpc;
    taken = bv && (ne ? (a != b) : (a == b));
    #1;
    if (!r) check(tag, "flush", {31'b0, flush}, {31'b0, taken});
    fetched = mem_word(m_pc);
    if (r) begin
      m_pc = 0; m_instr = 0; m_valid = 0;
    end else begin
      if (taken) m_pc = dpc + 32'd4 + imm * 32'd4;
      else if (!s) m_pc = m_pc + 32'd4;
      if (taken) begin m_instr = 0; m_valid = 0; end
      else if (!s) begin m_instr = fetched; m_valid = 1; end
    end
    @(posedge clk); #1;
    check(tag, "fetch_pc", fetch_pc, m_pc);
    check(tag, "dec_instr", dec_instr, m_instr);
    check(tag, "dec_valid", {31'b0, dec_valid}, {31'b0, m_valid});
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
    // R2 sequential
    for (int k = 0; k < 4; k++) step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 equal taken: 40 + 4 + 7*4 = 72
    step("R3", 0, 0, 1, 0, 32'h55, 32'h55, 32'd7, 32'd40);
    check("R3", "target72", fetch_pc, 32'd72);
    // R6 squashed slot, then sequential resumes
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    // R3 backward: 100 + 4 - 12 = 92
    step("R3", 0, 0, 1, 0, 32'hFFFF_0000, 32'hFFFF_0000, -32'sd3, 32'd100);
    // R5 equal-type with different operands
    step("R5", 0, 0, 1, 0, 32'd1, 32'd2, 32'd9, 32'd8);
    // R4 not-equal taken: 200 + 4 + 64 = 268
    step("R4", 0, 0, 1, 1, 32'd1, 32'h8000_0001, 32'h10, 32'd200);
    // R5 not-equal-type with equal operands
    step("R5", 0, 0, 1, 1, 32'hABCD, 32'hABCD, 32'h10, 32'd200);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 stall hold
    step("R7", 0, 1, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 1, 1, 0, 32'd3, 32'd4, 32'd5, 32'd6);
    // R8 flush beats stall
    step("R8", 0, 1, 1, 0, 32'd7, 32'd7, 32'd2, 32'd500);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    // R9 branch flag low with equal operands
    step("R9", 0, 0, 0, 0, 32'd9, 32'd9, 32'd100, 32'd1000);
    step("R9", 0, 0, 0, 1, 32'd1, 32'd2, 32'd100, 32'd1000);
    // R1 reset mid-run
    step("R1", 1, 0, 1, 0, 32'd0, 32'd0, 32'd4, 32'd4);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule